// File: doc/BRIEF.md
# Dual-Slot Microcode Sequencer with Hazard Interlock

The block accepts up to two decoded instructions from a two-lane front end, lane 0 preceding lane 1 in program order, and holds each one in its own slot. Each slot runs a private step counter through a small synchronous microcode table. Each step yields one vertical micro-operation. A slot's micro-operation sits on its output until the slot may issue it. A 2:1 selector in front of every slot lets an instruction land in whichever slot is free, and an age flag records which resident instruction came first.

A hazard checker compares the two pending micro-operations every cycle. The older one always issues. The younger one is held, with its step counter frozen, when it reads or rewrites a register the older one writes, or when both want the ALU or both want the memory port. The issued pair, with per-slot valid flags and the age flag, goes to a later packing stage. A slot becomes free again in the cycle after its final step issues.

Top module: `dual_useq`

## Requirements
- R1: Lane 0 is taken (`take_o[0]`) when it is valid and at least one slot is free. Lane 1 is taken (`take_o[1]`) only when both lanes are valid and both slots are free. A lane 1 request on its own is ignored and starts nothing.
- R2: When both slots are free, lane 0 goes to slot 0 and lane 1 goes to slot 1. When only slot j is free, lane 0 goes to slot j. Slot k always drives `uop_o[k]`.
- R3: `old_o` names the slot holding the older instruction. After a paired load it is 0. A single load into one slot while the other is still busy makes the newcomer the younger one. A slot left busy alone is the older one.
- R4: A loaded slot presents step 0 in the cycle after it is taken and issues at most one micro-operation per cycle. Its `slot_free_o` bit rises in the cycle after its last step issues.
- R5: A conflict exists when the older micro-operation writes a register that the younger one reads or writes, or when both use the ALU, or when both use the memory port. On a conflict only the older slot's `uop_vld_o` bit is set. The older slot issues whenever it is busy.
- R6: Two busy slots without a conflict both issue in the same cycle.
- R7: A held slot keeps its step and presents the same micro-operation until it issues.
- R8: Micro-operation encoding: bits 4:0 are reads and bits 9:5 are writes, each using the register order A, X, Y, P, S from the low bit up. Bit 10 is the ALU, bit 11 is the memory port and bit 12 marks the last step. The opcodes are as follows. 0 is one empty step. 1 is one step: memory, write A. 2 is one step: ALU, read A, write X. 3 is one step: ALU, read X, write X and P. 4 is memory, then memory with read A. 5 is memory, then ALU with read A and P and write A and P. 6 is ALU with read S and write S, then memory with read A. 7 is memory, memory, ALU with write P, then memory.
- R9: While `rst_ni` is low, no `uop_vld_o` bit is set and both slots are free, including when reset arrives mid-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_vld_i | input | 2 | Per-lane instruction valid, lane 0 first in program order |
| lane_op_i | input | 2x3 | Per-lane opcode |
| take_o | output | 2 | Lane accepted this cycle |
| slot_free_o | output | 2 | Slot holds no instruction |
| uop_o | output | 2x13 | Pending micro-operation of each slot |
| uop_vld_o | output | 2 | Slot issues its micro-operation this cycle |
| old_o | output | 1 | Index of the slot holding the older instruction |

## Verification
The assertions assume the front end never offers lane 1 without lane 0. They also assume lane opcodes are stable while sampled, and that an instruction counts as accepted only through `take_o`. The stimulus drives both lanes only together or lane 0 alone, with one deliberate lane-1-only case to show it is ignored. The stimulus changes inputs only at the falling edge. Instruction pairs are chosen so that read-after-write, write-after-write, ALU and memory-port clashes each occur, alongside pairs that issue together.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W   = 3;
  localparam int STEP_W = 2;
  localparam int NREG   = 5;
  localparam int NSLOT  = 2;

  localparam int RG_A = 0;
  localparam int RG_X = 1;
  localparam int RG_Y = 2;
  localparam int RG_P = 3;
  localparam int RG_S = 4;

  typedef struct packed {
    logic            last;
    logic            mem;
    logic            alu;
    logic [NREG-1:0] wr;
    logic [NREG-1:0] rd;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 3'd0,
    OP_LOAD_A   = 3'd1,
    OP_MOVE_AX  = 3'd2,
    OP_INC_X    = 3'd3,
    OP_STORE_A  = 3'd4,
    OP_ADD_MEM  = 3'd5,
    OP_PUSH_A   = 3'd6,
    OP_INC_MEM  = 3'd7
  } op_e;
endpackage

// File: rtl/useq_rom.sv
module useq_rom import useq_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [STEP_W-1:0] step_i,
  output uop_t              uop_o
);
  uop_t uop_q;

  function automatic uop_t lookup(input logic [OP_W-1:0] op, input logic [STEP_W-1:0] st);
    uop_t u;
    u      = '0;
    u.last = 1'b1;
    case (op_e'(op))
      OP_LOAD_A: begin
        u.mem = 1'b1; u.wr[RG_A] = 1'b1;
      end
      OP_MOVE_AX: begin
        u.alu = 1'b1; u.rd[RG_A] = 1'b1; u.wr[RG_X] = 1'b1;
      end
      OP_INC_X: begin
        u.alu = 1'b1; u.rd[RG_X] = 1'b1; u.wr[RG_X] = 1'b1; u.wr[RG_P] = 1'b1;
      end
      OP_STORE_A: begin
        u.mem = 1'b1;
        if (st == '0) u.last = 1'b0;
        else          u.rd[RG_A] = 1'b1;
      end
      OP_ADD_MEM: begin
        if (st == '0) begin
          u.mem = 1'b1; u.last = 1'b0;
        end else begin
          u.alu = 1'b1;
          u.rd[RG_A] = 1'b1; u.rd[RG_P] = 1'b1;
          u.wr[RG_A] = 1'b1; u.wr[RG_P] = 1'b1;
        end
      end
      OP_PUSH_A: begin
        if (st == '0) begin
          u.alu = 1'b1; u.rd[RG_S] = 1'b1; u.wr[RG_S] = 1'b1; u.last = 1'b0;
        end else begin
          u.mem = 1'b1; u.rd[RG_A] = 1'b1;
        end
      end
      OP_INC_MEM: begin
        case (st)
          2'd0, 2'd1: begin u.mem = 1'b1; u.last = 1'b0; end
          2'd2:       begin u.alu = 1'b1; u.wr[RG_P] = 1'b1; u.last = 1'b0; end
          default:    u.mem = 1'b1;
        endcase
      end
      default: ;
    endcase
    return u;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      uop_q <= '0;
    else if (rd_en_i) uop_q <= lookup(op_i, step_i);
  end

  assign uop_o = uop_q;
endmodule

// File: rtl/useq_slot.sv
module useq_slot import useq_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            grant_i,
  output logic            busy_o,
  output logic            fin_o,
  output uop_t            uop_o
);
  logic              busy_q;
  logic [OP_W-1:0]   op_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nx;
  logic              adv;
  logic              rom_en;
  logic [OP_W-1:0]   rom_op;
  logic [STEP_W-1:0] rom_st;
  uop_t              uop_cur;

  assign adv     = grant_i & busy_q;
  assign fin_o   = adv & uop_cur.last;
  assign step_nx = step_q + 1'b1;

  // table output register is the pending micro-op; read next step only on advance
  assign rom_en = load_i | (adv & ~uop_cur.last);
  assign rom_op = load_i ? op_i : op_q;
  assign rom_st = load_i ? '0 : step_nx;

  useq_rom u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rom_en),
    .op_i    (rom_op),
    .step_i  (rom_st),
    .uop_o   (uop_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      step_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      step_q <= '0;
    end else if (adv) begin
      if (uop_cur.last) busy_q <= 1'b0;
      else              step_q <= step_nx;
    end
  end

  assign busy_o = busy_q;
  assign uop_o  = uop_cur;
endmodule

// File: rtl/useq_dep.sv
module useq_dep import useq_pkg::*; (
  input  logic [NSLOT-1:0] pend_i,
  input  uop_t [NSLOT-1:0] uop_i,
  input  logic             old_i,
  output logic [NSLOT-1:0] grant_o
);
  uop_t uo;
  uop_t uy;
  logic yng;
  logic clash;

  assign yng = ~old_i;
  assign uo  = uop_i[old_i];
  assign uy  = uop_i[yng];

  assign clash = (|(uo.wr & (uy.rd | uy.wr))) | (uo.alu & uy.alu) | (uo.mem & uy.mem);

  always_comb begin
    grant_o       = '0;
    grant_o[old_i] = pend_i[old_i];
    grant_o[yng]   = pend_i[yng] & ~(pend_i[old_i] & clash);
  end
endmodule

// File: rtl/dual_useq.sv
module dual_useq import useq_pkg::*; (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSLOT-1:0]           lane_vld_i,
  input  logic [NSLOT-1:0][OP_W-1:0] lane_op_i,
  output logic [NSLOT-1:0]           take_o,
  output logic [NSLOT-1:0]           slot_free_o,
  output logic [NSLOT-1:0][UOP_W-1:0] uop_o,
  output logic [NSLOT-1:0]           uop_vld_o,
  output logic                       old_o
);
  logic [NSLOT-1:0] busy;
  logic [NSLOT-1:0] fin;
  logic [NSLOT-1:0] load;
  logic [NSLOT-1:0] grant;
  logic [NSLOT-1:0] sel;
  uop_t [NSLOT-1:0] uop;
  logic             both_free;
  logic             any_free;
  logic             old_q;
  logic             old_eff;

  assign both_free = ~|busy;
  assign any_free  = ~&busy;

  assign take_o[0] = lane_vld_i[0] & any_free;
  assign take_o[1] = lane_vld_i[1] & lane_vld_i[0] & both_free;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [OP_W-1:0] op_mux;
    // input swap: lane k when pairing, else lane 0 into whichever slot is free
    assign sel[k]  = both_free ? (k == 1) : 1'b0;
    assign op_mux  = lane_op_i[sel[k]];
    assign load[k] = both_free ? take_o[k] : (~busy[k] & take_o[0]);

    useq_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load[k]),
      .op_i    (op_mux),
      .grant_i (grant[k]),
      .busy_o  (busy[k]),
      .fin_o   (fin[k]),
      .uop_o   (uop[k])
    );

    assign uop_o[k] = uop[k];
  end

  always_comb begin
    case (busy)
      2'b01:   old_eff = 1'b0;
      2'b10:   old_eff = 1'b1;
      default: old_eff = old_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             old_q <= 1'b0;
    else if (load == 2'b11)  old_q <= 1'b0;
    else if (load[0])        old_q <= busy[1] & ~fin[1];
    else if (load[1])        old_q <= ~(busy[0] & ~fin[0]);
    else if (fin[old_eff])   old_q <= ~old_eff;
  end

  useq_dep u_dep (
    .pend_i  (busy),
    .uop_i   (uop),
    .old_i   (old_eff),
    .grant_o (grant)
  );

  assign uop_vld_o   = grant;
  assign slot_free_o = ~busy;
  assign old_o       = old_eff;
endmodule

// File: rtl/dual_useq_chk.sv
module dual_useq_chk import useq_pkg::*; (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NSLOT-1:0]            busy_i,
  input logic [NSLOT-1:0]            take_i,
  input logic [NSLOT-1:0][UOP_W-1:0] uop_i,
  input logic [NSLOT-1:0]            vld_i,
  input logic                        old_i
);
  uop_t uo;
  uop_t uy;
  logic pair_clash;

  assign uo = uop_t'(uop_i[old_i]);
  assign uy = uop_t'(uop_i[~old_i]);
  assign pair_clash = (|(uo.wr & (uy.rd | uy.wr))) | (uo.alu & uy.alu) | (uo.mem & uy.mem);

  p_lane_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i[1] |-> take_i[0]);

  p_take_needs_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i[0] |-> !(busy_i[0] && busy_i[1]));

  p_issue_needs_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i & ~busy_i) == '0);

  p_older_goes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[old_i] |-> vld_i[old_i]);

  p_no_clash_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i == 2'b11) |-> !pair_clash);

  p_pair_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i == 2'b11 && !pair_clash) |-> vld_i == 2'b11);

  p_hold_slot0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i[0] && !vld_i[0]) |=> (busy_i[0] && $stable(uop_i[0])));

  p_hold_slot1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i[1] && !vld_i[1]) |=> (busy_i[1] && $stable(uop_i[1])));
endmodule

bind dual_useq dual_useq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy),
  .take_i (take_o),
  .uop_i  (uop_o),
  .vld_i  (uop_vld_o),
  .old_i  (old_o)
);

// File: tb/dual_useq_tb.sv
`timescale 1ns/1ps
module dual_useq_tb;
  logic            clk;
  logic            rst_n;
  logic [1:0]      lane_vld;
  logic [1:0][2:0] lane_op;
  logic [1:0]      take;
  logic [1:0]      sfree;
  logic [1:0][12:0] uop;
  logic [1:0]      uvld;
  logic            old;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  dual_useq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lane_vld_i(lane_vld), .lane_op_i(lane_op),
    .take_o(take), .slot_free_o(sfree), .uop_o(uop), .uop_vld_o(uvld), .old_o(old)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {older op, younger op, slot0 issue per cycle 1..5 (lsb first), slot1 likewise}
  localparam logic [15:0] VEC [8] = '{
    {3'd1, 3'd2, 5'b00001, 5'b00010},
    {3'd2, 3'd3, 5'b00001, 5'b00010},
    {3'd0, 3'd1, 5'b00001, 5'b00001},
    {3'd1, 3'd3, 5'b00001, 5'b00001},
    {3'd4, 3'd6, 5'b00011, 5'b00101},
    {3'd7, 3'd2, 5'b01111, 5'b00001},
    {3'd5, 3'd5, 5'b00011, 5'b00110},
    {3'd6, 3'd1, 5'b00011, 5'b00001}
  };

  // R8 encoding: rd[4:0], wr[9:5], alu 10, mem 11, last 12; regs A0 X1 Y2 P3 S4
  function automatic logic [12:0] exp_uop(input logic [2:0] op, input int st);
    case (op)
      3'd1: return 13'h1800 | (13'd1 << 5);
      3'd2: return 13'h1400 | (13'd1 << 6) | 13'd1;
      3'd3: return 13'h1400 | (13'd1 << 6) | (13'd1 << 8) | 13'd2;
      3'd4: return (st == 0) ? 13'h0800 : (13'h1800 | 13'd1);
      3'd5: return (st == 0) ? 13'h0800 : (13'h1400 | 13'd9 | (13'd9 << 5));
      3'd6: return (st == 0) ? (13'h0400 | 13'd16 | (13'd16 << 5)) : (13'h1800 | 13'd1);
      3'd7: return (st < 2) ? 13'h0800 : (st == 2) ? (13'h0400 | (13'd8 << 5)) : 13'h1800;
      default: return 13'h1000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lane_vld = '0;
    lane_op = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset issue", uvld, 2'b00);
    chk("R9 reset free", sfree, 2'b11);
    rst_n = 1'b1;
    cyc();
    chk("R1 idle take", take, 2'b00);
    chk("R3 idle old", old, 1'b0);

    // R1: lane 1 alone is ignored
    lane_vld = 2'b10; lane_op[1] = 3'd1;
    #1 chk("R1 lane1 alone take", take, 2'b00);
    cyc();
    lane_vld = 2'b00;
    chk("R1 lane1 alone no issue", uvld, 2'b00);
    chk("R1 lane1 alone free", sfree, 2'b11);

    // pair vectors: R5 R6 R4 R8
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = VEC[i];
      cyc();
      lane_vld = 2'b11;
      lane_op[0] = v[15:13];
      lane_op[1] = v[12:10];
      #1 chk("R1 pair take", take, 2'b11);
      cyc();
      lane_vld = 2'b00;
      for (int c = 1; c <= 5; c++) begin
        if (c > 1) cyc();
        chk("R5 R6 issue pattern", uvld, {v[c-1], v[4+c]});
        if (c == 1) begin
          chk("R8 slot0 step0", uop[0], exp_uop(v[15:13], 0));
          chk("R2 R8 slot1 step0", uop[1], exp_uop(v[12:10], 0));
          chk("R3 pair old", old, 1'b0);
        end
      end
      chk("R4 free after last", sfree, 2'b11);
    end

    // single load into slot 1 while slot 0 busy: R2 R3 R5 R7
    cyc();
    lane_vld = 2'b11; lane_op[0] = 3'd7; lane_op[1] = 3'd0;
    cyc();
    lane_vld = 2'b00;
    chk("R6 inc_mem+nop", uvld, 2'b11);
    cyc();
    chk("R4 slot1 freed", sfree, 2'b10);
    lane_vld = 2'b11; lane_op[0] = 3'd3; lane_op[1] = 3'd0;
    #1 chk("R1 one free take", take, 2'b01);
    chk("R4 one uop per cycle", uvld, 2'b01);
    cyc();
    lane_vld = 2'b00;
    chk("R5 alu and P write clash", uvld, 2'b01);
    chk("R3 newcomer younger", old, 1'b0);
    chk("R2 lane0 into slot1", uop[1], exp_uop(3'd3, 0));
    cyc();
    chk("R7 held now issues", uvld, 2'b11);
    chk("R7 held uop kept", uop[1], exp_uop(3'd3, 0));
    cyc();
    chk("R4 both free", sfree, 2'b11);

    // age passes to remaining slot: r3_
    cyc();
    lane_vld = 2'b11; lane_op[0] = 3'd5; lane_op[1] = 3'd5;
    cyc();
    lane_vld = 2'b00;
    cyc();
    cyc();
    chk("R3 survivor older", old, 1'b1);
    chk("R5 survivor issues", uvld, 2'b10);
    lane_vld = 2'b01; lane_op[0] = 3'd1;
    #1 chk("R1 refill free slot0", take, 2'b01);
    cyc();
    lane_vld = 2'b00;
    chk("R3 refill alone old", old, 1'b0);
    chk("R4 refill issue", uvld, 2'b01);
    cyc();

    // reset mid-instruction: R9
    lane_vld = 2'b11; lane_op[0] = 3'd7; lane_op[1] = 3'd4;
    cyc();
    lane_vld = 2'b00;
    rst_n = 1'b0;
    #1 chk("R9 mid reset issue", uvld, 2'b00);
    chk("R9 mid reset free", sfree, 2'b11);
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R9 after reset idle", uvld, 2'b00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule